// File: doc/BRIEF.md
# Synchronous DRAM Burst Column Sequencer

This block models the column side of a single-data-rate synchronous DRAM device. A mode-set command copies a configuration word from the address bus into a configuration register: the burst length, the beat ordering and the read latency. Each later read or write command carries a starting column. The sequencer then steps through the burst one beat per clock and puts each beat's column on an output. For reads it returns the data from a small behavioural page array after the programmed latency, and it drives an output-enable that falls when the bus is released.

A burst ends on its own after its programmed length. A burst-stop command ends it early, and so does a new read or write. In full-page mode the burst never ends on its own. It walks the whole page from any starting column, wraps past the last column back to column 0, and continues until it is stopped or replaced. A write beat stores the data presented in the same clock cycle that shows its column.

Top module: `sdc_col_seq`

## Requirements
- R1: Command codes on `cmd_i` are 0 no-op, 1 mode-set, 2 read, 3 write and 4 burst-stop; 5 to 7 act as no-op. A mode-set takes the burst length from address bits 2..0 (000=1, 001=2, 010=4, 011=8, 111=full page), the ordering from bit 3 (0 sequential, 1 interleaved) and the read latency from bits 6..4 (010=2, 011=3). The setting is held until the next accepted mode-set.
- R2: After reset the setting is burst length 1, sequential, latency 2. Read, write and burst-stop commands have no effect until the first accepted mode-set. `col_vld_o`, `dq_oe_o` and `dq_o` stay low.
- R3: A mode-set is ignored, leaving the setting unchanged, if its burst-length code is 100, 101 or 110, if its latency code is anything other than 010 or 011, or if it arrives while a burst or read data is still in flight.
- R4: In sequential order, beat i of a burst of length L starting at column S shows column (S with its low log2(L) bits cleared) plus ((S + i) mod L).
- R5: In interleaved order, beat i shows S with its low log2(L) bits replaced by the low bits of S XOR i. Higher column bits do not change.
- R6: A burst of length 1, 2, 4 or 8 issues exactly that many beats on consecutive cycles, the first in the cycle after the command. `col_vld_o` then falls, and for a read `dq_oe_o` falls in the cycle after the last data beat.
- R7: In full-page mode the burst starts at any column, steps by one column per cycle, wraps from the last column to column 0, and continues until a burst-stop or a new read or write arrives. Full-page mode always uses sequential order.
- R8: With a burst-stop in the cycle of beat n, beat n is the last beat. The data of every read beat already issued still appears at its normal latency.
- R9: The data of a read beat 0 appears on `dq_o` with `dq_oe_o` high in the cycle that starts latency-many clock edges after the edge that sampled the read. Later beats follow on consecutive cycles.
- R10: The value on `wr_data_i` during a write beat cycle is stored at the column that `col_o` shows in that cycle, and a later read returns it.
- R11: A read or write arriving during a burst ends that burst after its current beat. The new burst's beat 0 appears in the next cycle at the new starting column.
- R12: While `dq_oe_o` is low, `dq_o` is all zeros, standing for a released bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Command code, sampled each rising edge |
| addr_i | input | max(COL_W,7) | Starting column, or the configuration word during a mode-set |
| wr_data_i | input | DW | Write data for the current write beat |
| col_o | output | COL_W | Column of the current beat |
| col_vld_o | output | 1 | A beat is active this cycle |
| dq_o | output | DW | Read data (zero when released) |
| dq_oe_o | output | 1 | Read data output enable |

## Verification
The bench first fills the whole page with a full-page write. It then reads the page back under each ordering, length and latency, so a wrong block base or XOR ordering shows up as wrong data as well as a wrong column. Wrap-around is tested with a full-page read from column 500 that is stopped after 20 beats. A sequencer that clamped at the page end, or ran past the stop, would show extra or wrong columns and data. Truncation by a new read is tested with latency 2, where the old burst's data runs straight into the new one's. A design that dropped in-flight beats would leave a gap in the output enable. Mode-sets with reserved codes, and one issued while read data is still in flight, must leave the old length and latency in force. A design that accepted either would move the data by a cycle.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_MODE = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_STOP = 3'd4
    } cmd_e;

    localparam logic [2:0] BL_FULL = 3'b111;

    typedef struct packed {
        logic [2:0] bl;   // burst length code
        logic       ilv;  // 1 = interleaved order
        logic [1:0] cl;   // read latency in clocks (2 or 3)
    } mode_t;

    function automatic logic bl_code_ok(input logic [2:0] code);
        return (code <= 3'd3) || (code == BL_FULL);
    endfunction

    function automatic logic cl_code_ok(input logic [2:0] code);
        return (code == 3'd2) || (code == 3'd3);
    endfunction

endpackage

// File: rtl/sdc_mode_reg.sv
module sdc_mode_reg
    import sdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [6:0] fld_i,
    output mode_t      mode_o,
    output logic       cfg_o
);

    typedef struct packed {
        mode_t mode;
        logic  cfg;
    } mreg_t;

    mreg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i && bl_code_ok(fld_i[2:0]) && cl_code_ok(fld_i[6:4])) begin
            st_d.mode.bl  = fld_i[2:0];
            st_d.mode.ilv = fld_i[3];
            st_d.mode.cl  = fld_i[5:4];
            st_d.cfg      = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= '{bl: 3'd0, ilv: 1'b0, cl: 2'd2};
            st_q.cfg  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;
    assign cfg_o  = st_q.cfg;

    // R1
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load_i) |-> $stable(mode_o));

    // R2
    cfg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_o |=> cfg_o);

endmodule

// File: rtl/sdc_burst_gen.sv
module sdc_burst_gen
    import sdc_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_i,
    input  logic             wr_i,
    input  logic             stop_i,
    input  logic [COL_W-1:0] start_i,
    input  logic [2:0]       bl_i,
    input  logic             ilv_i,
    output logic             beat_o,
    output logic             rd_beat_o,
    output logic             wr_beat_o,
    output logic [COL_W-1:0] col_o
);

    typedef struct packed {
        logic             act;
        logic             rd;
        logic             full;
        logic             ilv;
        logic [COL_W-1:0] start;
        logic [COL_W-1:0] idx;
        logic [COL_W-1:0] mask;
    } burst_t;

    burst_t s_d, s_q;
    logic [COL_W-1:0] off;

    always_comb begin
        s_d = s_q;
        if (rd_i || wr_i) begin
            s_d.act   = 1'b1;
            s_d.rd    = rd_i;
            s_d.start = start_i;
            s_d.idx   = '0;
            s_d.full  = (bl_i == BL_FULL);
            s_d.mask  = (bl_i == BL_FULL) ? '1 : COL_W'((1 << bl_i) - 1);
            s_d.ilv   = ilv_i && (bl_i != BL_FULL);
        end else if (stop_i) begin
            s_d.act = 1'b0;
        end else if (s_q.act) begin
            if (!s_q.full && (s_q.idx == s_q.mask)) begin
                s_d.act = 1'b0;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign off       = s_q.ilv ? (s_q.start ^ s_q.idx) : (s_q.start + s_q.idx);
    assign col_o     = (s_q.start & ~s_q.mask) | (off & s_q.mask);
    assign beat_o    = s_q.act;
    assign rd_beat_o = s_q.act && s_q.rd;
    assign wr_beat_o = s_q.act && !s_q.rd;

    // R7
    full_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.act && s_q.full && !rd_i && !wr_i && !stop_i) |=> beat_o);

    // R4 R5
    block_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.act && !s_q.full && $past(s_q.act && !rd_i && !wr_i))
        |-> ((col_o & ~s_q.mask) == $past(col_o & ~s_q.mask)));

    // R8
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !rd_i && !wr_i) |=> !beat_o);

    // R11
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i || wr_i) |=> (beat_o && (col_o == $past(start_i))));

endmodule

// File: rtl/sdc_rd_pipe.sv
module sdc_rd_pipe #(
    parameter int DW     = 8,
    parameter int MAX_CL = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_i,
    input  logic [DW-1:0] data_i,
    input  logic [1:0]    cl_i,
    output logic          oe_o,
    output logic [DW-1:0] data_o,
    output logic          busy_o
);

    typedef struct packed {
        logic          v;
        logic [DW-1:0] d;
    } stage_t;

    stage_t stg_d [MAX_CL];
    stage_t stg_q [MAX_CL];

    always_comb begin
        stg_d[0].v = vld_i;
        stg_d[0].d = data_i;
        for (int k = 1; k < MAX_CL; k++) begin
            stg_d[k] = stg_q[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < MAX_CL; k++) begin
                stg_q[k] <= '0;
            end
        end else begin
            for (int k = 0; k < MAX_CL; k++) begin
                stg_q[k] <= stg_d[k];
            end
        end
    end

    always_comb begin
        oe_o   = 1'b0;
        data_o = '0;
        busy_o = 1'b0;
        for (int k = 0; k < MAX_CL; k++) begin
            busy_o = busy_o | stg_q[k].v;
            if (((k + 1) == int'(cl_i)) && stg_q[k].v) begin
                oe_o   = 1'b1;
                data_o = stg_q[k].d;
            end
        end
    end

    // R9
    lat2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o && cl_i == 2'd2) |-> $past(vld_i, 2));

    // R9
    lat3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o && cl_i == 2'd3) |-> $past(vld_i, 3));

endmodule

// File: rtl/sdc_page_mem.sv
module sdc_page_mem #(
    parameter int COL_W = 9,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [COL_W-1:0] addr_i,
    input  logic [DW-1:0]    wd_i,
    output logic [DW-1:0]    rd_o
);

    localparam int NCOL = 1 << COL_W;

    logic [DW-1:0] mem_q [NCOL];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[addr_i] <= wd_i;
        end
    end

    assign rd_o = mem_q[addr_i];

endmodule

// File: rtl/sdc_col_seq.sv
module sdc_col_seq
    import sdc_pkg::*;
#(
    parameter  int COL_W  = 9,
    parameter  int DW     = 8,
    parameter  int MAX_CL = 3,
    localparam int AW     = (COL_W > 7) ? COL_W : 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cmd_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    wr_data_i,
    output logic [COL_W-1:0] col_o,
    output logic             col_vld_o,
    output logic [DW-1:0]    dq_o,
    output logic             dq_oe_o
);

    mode_t            mode;
    logic             cfg;
    logic             beat, rd_beat, wr_beat;
    logic             pipe_busy;
    logic             busy;
    logic             mode_ld, rd_go, wr_go, stop_go;
    logic [COL_W-1:0] col;
    logic [DW-1:0]    mem_rd;

    assign busy    = beat || pipe_busy;
    assign mode_ld = (cmd_i == CMD_MODE) && !busy;
    assign rd_go   = (cmd_i == CMD_RD)   && cfg;
    assign wr_go   = (cmd_i == CMD_WR)   && cfg;
    assign stop_go = (cmd_i == CMD_STOP) && cfg;

    sdc_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (mode_ld),
        .fld_i  (addr_i[6:0]),
        .mode_o (mode),
        .cfg_o  (cfg)
    );

    sdc_burst_gen #(.COL_W(COL_W)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_i      (rd_go),
        .wr_i      (wr_go),
        .stop_i    (stop_go),
        .start_i   (addr_i[COL_W-1:0]),
        .bl_i      (mode.bl),
        .ilv_i     (mode.ilv),
        .beat_o    (beat),
        .rd_beat_o (rd_beat),
        .wr_beat_o (wr_beat),
        .col_o     (col)
    );

    sdc_page_mem #(.COL_W(COL_W), .DW(DW)) u_mem (
        .clk    (clk),
        .we_i   (wr_beat),
        .addr_i (col),
        .wd_i   (wr_data_i),
        .rd_o   (mem_rd)
    );

    sdc_rd_pipe #(.DW(DW), .MAX_CL(MAX_CL)) u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (rd_beat),
        .data_i (mem_rd),
        .cl_i   (mode.cl),
        .oe_o   (dq_oe_o),
        .data_o (dq_o),
        .busy_o (pipe_busy)
    );

    assign col_o     = col;
    assign col_vld_o = beat;

    // R2
    no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg |-> (!col_vld_o && !dq_oe_o));

endmodule

// File: tb/sdc_col_seq_test.sv
module sdc_col_seq_test;
    import sdc_pkg::*;

    localparam int COL_W = 9;
    localparam int DW    = 8;
    localparam int AW    = 9;
    localparam int NCOL  = 512;
    localparam int NS    = 600;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       cmd = 3'd0;
    logic [AW-1:0]    addr = '0;
    logic [DW-1:0]    wd = '0;
    logic [COL_W-1:0] col;
    logic             col_vld;
    logic [DW-1:0]    dq;
    logic             dq_oe;

    sdc_col_seq uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_i     (cmd),
        .addr_i    (addr),
        .wr_data_i (wd),
        .col_o     (col),
        .col_vld_o (col_vld),
        .dq_o      (dq),
        .dq_oe_o   (dq_oe)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;

    int   ref_mem [NCOL];
    bit   e_cv    [NS];
    int   e_col   [NS];
    bit   e_oe    [NS];
    int   e_d     [NS];
    int   s_cmd   [NS];
    int   s_addr  [NS];
    int   s_wd    [NS];

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int col_of(int start, int blen, bit ilv, int i);
        int mask = blen - 1;
        int off  = ilv ? (start ^ i) : (start + i);
        return (start & ~mask) | (off & mask);
    endfunction

    task automatic clear_sched();
        for (int s = 0; s < NS; s++) begin
            e_cv[s] = 0; e_col[s] = 0; e_oe[s] = 0; e_d[s] = 0;
            s_cmd[s] = int'(CMD_NOP); s_addr[s] = 0; s_wd[s] = 0;
        end
    endtask

    task automatic add_cmd(int k, cmd_e c, int a);
        s_cmd[k]  = int'(c);
        s_addr[k] = a;
    endtask

    task automatic add_mode(int k, int blc, int ilv, int clc);
        add_cmd(k, CMD_MODE, (clc << 4) | (ilv << 3) | blc);
    endtask

    task automatic add_rd(int k, int start, int blen, bit ilv, int cl, int nb);
        add_cmd(k, CMD_RD, start);
        for (int i = 0; i < nb; i++) begin
            int c = col_of(start, blen, ilv, i);
            e_cv[k+1+i]     = 1;
            e_col[k+1+i]    = c;
            e_oe[k+1+cl+i]  = 1;
            e_d[k+1+cl+i]   = ref_mem[c];
        end
    endtask

    task automatic add_wr(int k, int start, int blen, bit ilv, int nb, int seed);
        add_cmd(k, CMD_WR, start);
        for (int i = 0; i < nb; i++) begin
            int c = col_of(start, blen, ilv, i);
            int v = (c * 7 + seed) & 255;
            e_cv[k+1+i]  = 1;
            e_col[k+1+i] = c;
            s_wd[k+1+i]  = v;
            ref_mem[c]   = v;
        end
    endtask

    task automatic run_sched(int n, string req);
        for (int s = 0; s < n; s++) begin
            @(negedge clk);
            chk(req, $sformatf("col_vld slot %0d", s), 32'(col_vld), 32'(e_cv[s]));
            if (e_cv[s]) chk(req, $sformatf("col slot %0d", s), 32'(col), 32'(e_col[s]));
            chk(req, $sformatf("dq_oe slot %0d", s), 32'(dq_oe), 32'(e_oe[s]));
            chk(req, $sformatf("dq slot %0d", s), 32'(dq), 32'(e_d[s]));
            cmd  = s_cmd[s][2:0];
            addr = s_addr[s][AW-1:0];
            wd   = s_wd[s][DW-1:0];
        end
        cmd = 3'd0;
    endtask

    // R2 R12: idle outputs after reset
    task automatic t_reset();
        @(negedge clk);
        chk("R2", "col_vld after reset", 32'(col_vld), 0);
        chk("R2", "dq_oe after reset", 32'(dq_oe), 0);
        chk("R12", "dq after reset", 32'(dq), 0);
    endtask

    // R2: accesses before the first mode-set do nothing
    task automatic t_unconfigured();
        clear_sched();
        add_cmd(0, CMD_RD, 5);
        add_cmd(2, CMD_WR, 9);
        add_cmd(4, CMD_STOP, 0);
        run_sched(10, "R2");
    endtask

    // R1 R7 R10: full-page write fills the page, ended by burst-stop
    task automatic t_fill();
        clear_sched();
        add_mode(0, 7, 0, 2);
        add_wr(1, 0, NCOL, 0, NCOL, 3);
        add_cmd(513, CMD_STOP, 0);
        run_sched(517, "R7 R10");
    endtask

    // R1 R4 R6 R9 R12: sequential length 4, latency 2
    task automatic t_seq_bl4();
        clear_sched();
        add_mode(0, 2, 0, 2);
        add_rd(1, 6, 4, 0, 2, 4);
        run_sched(11, "R4 R6 R9");
    endtask

    // R5 R9: interleaved length 8, latency 3
    task automatic t_ilv_bl8();
        clear_sched();
        add_mode(0, 3, 1, 3);
        add_rd(1, 13, 8, 1, 3, 8);
        run_sched(16, "R5 R9");
    endtask

    // R6: lengths 2 and 1
    task automatic t_short();
        clear_sched();
        add_mode(0, 1, 0, 3);
        add_rd(1, 9, 2, 0, 3, 2);
        add_mode(8, 0, 0, 2);
        add_rd(9, 30, 1, 0, 2, 1);
        run_sched(15, "R6");
    endtask

    // R3: reserved codes and a mode-set while busy are ignored
    task automatic t_reserved();
        clear_sched();
        add_mode(0, 5, 0, 2);
        add_mode(1, 2, 0, 1);
        add_rd(2, 30, 1, 0, 2, 1);
        add_rd(7, 40, 1, 0, 2, 1);
        add_mode(9, 3, 0, 3);
        add_rd(13, 20, 1, 0, 2, 1);
        run_sched(19, "R3");
    endtask

    // R7 R8: full-page read wraps past the page end, stopped after 20 beats
    task automatic t_full_stop();
        clear_sched();
        add_mode(0, 7, 0, 3);
        add_rd(1, 500, NCOL, 0, 3, 20);
        add_cmd(21, CMD_STOP, 0);
        run_sched(28, "R7 R8");
    endtask

    // R10 R5: interleaved write then readback
    task automatic t_write_ilv();
        clear_sched();
        add_mode(0, 2, 1, 2);
        add_wr(1, 22, 4, 1, 4, 81);
        add_rd(6, 21, 4, 1, 2, 4);
        run_sched(15, "R10 R5");
    endtask

    // R11 R8: new read truncates, then burst-stop in a fixed burst
    task automatic t_truncate();
        clear_sched();
        add_mode(0, 3, 0, 2);
        add_rd(1, 3, 8, 0, 2, 3);
        add_rd(4, 40, 8, 0, 2, 8);
        add_rd(16, 16, 8, 0, 2, 3);
        add_cmd(19, CMD_STOP, 0);
        run_sched(24, "R11 R8");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCOL; c++) ref_mem[c] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unconfigured();
        t_fill();
        t_seq_bl4();
        t_ilv_bl8();
        t_short();
        t_reserved();
        t_full_stop();
        t_write_ilv();
        t_truncate();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule